// File: doc/BRIEF.md
# Page Access Permission Checker with Fault Recording

This block sits behind a page table walker. Once the walker has fetched the leaf entry, it hands over the entry's 3-bit access field and its modified bit, along with the kind of access (load, store or instruction fetch), the privilege of the requester and the virtual address. In the same cycle the block decides whether the access may go ahead. It also returns the read/write/execute permission set that the translation cache should install.

When an access is refused, the block records why in a fault status register and stores the address in a fault address register. A fault that arrives before software has read the previous one is marked as an overwrite. A software read clears the status register. Unless the access is excused, the block raises a trap request one cycle after the check, together with a class bit that separates instruction faults from data faults. A no-fault mode, or traps being globally disabled, turns a refused access into a fully permitted one without a trap. The fault is still recorded in that case.

Top module: `mmu_access_guard`

## Requirements
- R1: The access index is {write, fetch, supervisor}: bit 2 is set for stores, bit 1 for fetches and bit 0 for supervisor requests. A store-with-fetch index needs both write and execute rights. A store needs write, a fetch needs execute and anything else needs read.
- R2: Access field rights, written as user/supervisor: 0 R/R, 1 RW/RW, 2 RX/RX, 3 RWX/RWX, 4 X/X, 5 R/RW, 6 none/RX, 7 none/RWX. A user access to field 6 or 7 gives error code 12 (privilege). Any other missing right gives code 8 (protection). Otherwise the code is 0.
- R3: perm_rwx is {R,W,X} and is valid in the same cycle as chk_valid. When the entry's modified bit is clear, W is removed from the installed set of a permitted access.
- R4: With no-fault mode on, a user access never faults: there is no status update and no trap, and it receives its normal rights.
- R5: On a fault, a status value that is nonzero (and not being read in that cycle) first collapses to the overwrite flag, bit 0 = 1. All other old bits are dropped.
- R6: On a fault the status register takes the access index in bits [7:5], error code bits [3:2] in bits [3:2], and the address-valid flag in bit 1. The fault address register loads chk_vaddr.
- R7: A supervisor fault while no-fault mode is on, or any fault while traps are disabled, is still recorded, but chk_ok is 1, perm_rwx is 3'b111 and no trap is raised.
- R8: A fault that is not excused gives chk_ok = 0 and perm_rwx = 0. In the next cycle it gives trap_req = 1, with trap_is_fetch equal to the fetch bit of the access.
- R9: fsr_rd clears the status register on the following edge. A fault in the same cycle as fsr_rd is recorded with no overwrite flag. The fault address register is never cleared by a read.
- R10: After reset the status register, the address register and trap_req are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_valid | input | 1 | Check strobe |
| chk_perm | input | 3 | Access field of the leaf entry |
| chk_write | input | 1 | Access is a store |
| chk_fetch | input | 1 | Access is an instruction fetch |
| chk_super | input | 1 | Requester is supervisor |
| chk_modified | input | 1 | Modified bit of the leaf entry |
| chk_vaddr | input | VA_W | Virtual address of the access |
| nofault_mode | input | 1 | Suppress user faults and traps |
| traps_enable | input | 1 | Global trap enable |
| fsr_rd | input | 1 | Software read of the status register |
| perm_rwx | output | 3 | Permission set to install {R,W,X} |
| chk_ok | output | 1 | Access may proceed |
| trap_req | output | 1 | Registered trap request |
| trap_is_fetch | output | 1 | Trap class: 1 instruction, 0 data |
| fsr_q | output | 8 | Fault status register |
| far_q | output | VA_W | Fault address register |

## Verification
The bench drives a sweep of every combination of access index, access field, modified bit, no-fault mode and trap enable, so each cell of the error mapping is seen both with and without the privilege override. Status reads fall on every third check. This places faults over an unread status value (which separates the overwrite collapse from a plain OR) and over a read in the same cycle (which separates the precedence of the read from the fault). Pairs that differ only in the modified bit show whether write removal applies to permitted accesses only, and not to the full grant of an excused fault. A final idle read shows that the address register survives a clear.

// File: rtl/mmu_chk_pkg.sv
package mmu_chk_pkg;
  localparam int PERM_W = 3;
  localparam int IDX_W  = 3;
  localparam int ERR_W  = 4;
  localparam int FSR_W  = 8;
  localparam int FSR_IDX_LSB = 5;

  localparam logic [2:0] RIGHT_R = 3'b100;
  localparam logic [2:0] RIGHT_W = 3'b010;
  localparam logic [2:0] RIGHT_X = 3'b001;
  localparam logic [2:0] RIGHT_ALL = 3'b111;

  localparam logic [ERR_W-1:0] ERR_NONE = 4'd0;
  localparam logic [ERR_W-1:0] ERR_PROT = 4'd8;
  localparam logic [ERR_W-1:0] ERR_PRIV = 4'd12;

  typedef struct packed {
    logic wr;
    logic fe;
    logic sup;
  } acc_idx_t;
endpackage

// File: rtl/mmu_rights_decode.sv
module mmu_rights_decode
  import mmu_chk_pkg::*;
(
  input  logic [PERM_W-1:0] perm,
  input  logic              sup,
  output logic [2:0]        rights,
  output logic              user_locked
);
  always_comb begin
    rights = '0;
    case (perm)
      3'd0: rights = RIGHT_R;
      3'd1: rights = RIGHT_R | RIGHT_W;
      3'd2: rights = RIGHT_R | RIGHT_X;
      3'd3: rights = RIGHT_ALL;
      3'd4: rights = RIGHT_X;
      3'd5: rights = sup ? (RIGHT_R | RIGHT_W) : RIGHT_R;
      3'd6: rights = sup ? (RIGHT_R | RIGHT_X) : 3'b000;
      default: rights = sup ? RIGHT_ALL : 3'b000;
    endcase
    user_locked = !sup && (perm[2:1] == 2'b11);
  end
endmodule

// File: rtl/mmu_access_judge.sv
module mmu_access_judge
  import mmu_chk_pkg::*;
(
  input  logic             valid,
  input  acc_idx_t         idx,
  input  logic [2:0]       rights,
  input  logic             user_locked,
  input  logic             modified,
  input  logic             nofault,
  input  logic             traps_en,
  output logic [ERR_W-1:0] err_code,
  output logic             fault,
  output logic             take_trap,
  output logic             grant,
  output logic [2:0]       perm_out
);
  logic [2:0] need;
  logic       missing;
  logic       excused;

  always_comb begin
    need = idx.wr ? RIGHT_W : (idx.fe ? RIGHT_X : RIGHT_R);
    if (idx.wr && idx.fe) need = RIGHT_W | RIGHT_X;
    missing = (need & ~rights) != 3'b000;
    if (user_locked)  err_code = ERR_PRIV;
    else if (missing) err_code = ERR_PROT;
    else              err_code = ERR_NONE;

    fault     = valid && (err_code != ERR_NONE) && !(nofault && !idx.sup);
    excused   = nofault || !traps_en;
    take_trap = fault && !excused;
    grant     = valid && (!fault || excused);

    if (!valid)       perm_out = 3'b000;
    else if (fault)   perm_out = excused ? RIGHT_ALL : 3'b000;
    else              perm_out = modified ? rights : (rights & ~RIGHT_W);
  end
endmodule

// File: rtl/mmu_fault_regs.sv
module mmu_fault_regs
  import mmu_chk_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fault,
  input  acc_idx_t         idx,
  input  logic [ERR_W-1:0] err_code,
  input  logic [VA_W-1:0]  vaddr,
  input  logic             rd,
  output logic [FSR_W-1:0] fsr,
  output logic [VA_W-1:0]  far
);
  logic [FSR_W-1:0] base;
  logic [FSR_W-1:0] fsr_d;

  always_comb begin
    base  = rd ? '0 : fsr;
    fsr_d = base;
    if (fault) begin
      fsr_d = '0;
      fsr_d[FSR_IDX_LSB +: IDX_W] = idx;
      fsr_d[3:2] = err_code[3:2];
      fsr_d[1]   = 1'b1;
      fsr_d[0]   = (base != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsr <= '0;
      far <= '0;
    end else begin
      fsr <= fsr_d;
      if (fault) far <= vaddr;
    end
  end
endmodule

// File: rtl/mmu_trap_reg.sv
module mmu_trap_reg (
  input  logic clk,
  input  logic rst,
  input  logic take_trap,
  input  logic is_fetch,
  output logic trap_req,
  output logic trap_is_fetch
);
  always_ff @(posedge clk) begin
    if (rst) begin
      trap_req      <= 1'b0;
      trap_is_fetch <= 1'b0;
    end else begin
      trap_req      <= take_trap;
      trap_is_fetch <= take_trap && is_fetch;
    end
  end
endmodule

// File: rtl/mmu_access_guard.sv
module mmu_access_guard
  import mmu_chk_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chk_valid,
  input  logic [2:0]        chk_perm,
  input  logic              chk_write,
  input  logic              chk_fetch,
  input  logic              chk_super,
  input  logic              chk_modified,
  input  logic [VA_W-1:0]   chk_vaddr,
  input  logic              nofault_mode,
  input  logic              traps_enable,
  input  logic              fsr_rd,
  output logic [2:0]        perm_rwx,
  output logic              chk_ok,
  output logic              trap_req,
  output logic              trap_is_fetch,
  output logic [7:0]        fsr_q,
  output logic [VA_W-1:0]   far_q
);
  acc_idx_t         acc_idx;
  logic [2:0]       rights;
  logic             user_locked;
  logic [ERR_W-1:0] err_code;
  logic             fault_now;
  logic             take_trap;

  assign acc_idx = '{wr: chk_write, fe: chk_fetch, sup: chk_super};

  mmu_rights_decode u_rights (
    .perm        (chk_perm),
    .sup         (chk_super),
    .rights      (rights),
    .user_locked (user_locked)
  );

  mmu_access_judge u_judge (
    .valid       (chk_valid),
    .idx         (acc_idx),
    .rights      (rights),
    .user_locked (user_locked),
    .modified    (chk_modified),
    .nofault     (nofault_mode),
    .traps_en    (traps_enable),
    .err_code    (err_code),
    .fault       (fault_now),
    .take_trap   (take_trap),
    .grant       (chk_ok),
    .perm_out    (perm_rwx)
  );

  mmu_fault_regs #(.VA_W(VA_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .fault    (fault_now),
    .idx      (acc_idx),
    .err_code (err_code),
    .vaddr    (chk_vaddr),
    .rd       (fsr_rd),
    .fsr      (fsr_q),
    .far      (far_q)
  );

  mmu_trap_reg u_trap (
    .clk           (clk),
    .rst           (rst),
    .take_trap     (take_trap),
    .is_fetch      (chk_fetch),
    .trap_req      (trap_req),
    .trap_is_fetch (trap_is_fetch)
  );
endmodule

// File: rtl/mmu_access_guard_chk.sv
module mmu_access_guard_chk #(
  parameter int VA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            chk_valid,
  input logic [2:0]      chk_perm,
  input logic            chk_fetch,
  input logic            chk_super,
  input logic            chk_modified,
  input logic [VA_W-1:0] chk_vaddr,
  input logic            nofault_mode,
  input logic            traps_enable,
  input logic            fsr_rd,
  input logic [2:0]      perm_rwx,
  input logic            chk_ok,
  input logic            trap_req,
  input logic            trap_is_fetch,
  input logic [7:0]      fsr_q,
  input logic [VA_W-1:0] far_q,
  input logic            fault_now
);
  // R2: supervisor with field 3 or 7 holds every right
  p_super_full_r2: assert property (@(posedge clk) disable iff (rst)
    chk_valid && chk_super && (chk_perm == 3'd3 || chk_perm == 3'd7) |-> chk_ok && !fault_now);

  p_wclear_r3: assert property (@(posedge clk) disable iff (rst)
    chk_valid && !chk_modified && !fault_now |-> !perm_rwx[1]);

  p_nf_user_r4: assert property (@(posedge clk) disable iff (rst)
    chk_valid && nofault_mode && !chk_super |-> !fault_now);

  p_overwrite_r5: assert property (@(posedge clk) disable iff (rst)
    fault_now && !fsr_rd && (fsr_q != 8'd0) |=> fsr_q[0]);

  p_far_load_r6: assert property (@(posedge clk) disable iff (rst)
    fault_now |=> fsr_q[1] && (far_q == $past(chk_vaddr)));

  p_excused_r7: assert property (@(posedge clk) disable iff (rst)
    fault_now && (nofault_mode || !traps_enable) |-> chk_ok && perm_rwx == 3'b111 ##1 !trap_req);

  p_trap_class_r8: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> $past(fault_now) && (trap_is_fetch == $past(chk_fetch)));

  p_read_clear_r9: assert property (@(posedge clk) disable iff (rst)
    fsr_rd && !fault_now |=> fsr_q == 8'd0);

  p_far_keep_r9: assert property (@(posedge clk) disable iff (rst)
    !fault_now |=> $stable(far_q));
endmodule

bind mmu_access_guard mmu_access_guard_chk #(.VA_W(VA_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .chk_valid     (chk_valid),
  .chk_perm      (chk_perm),
  .chk_fetch     (chk_fetch),
  .chk_super     (chk_super),
  .chk_modified  (chk_modified),
  .chk_vaddr     (chk_vaddr),
  .nofault_mode  (nofault_mode),
  .traps_enable  (traps_enable),
  .fsr_rd        (fsr_rd),
  .perm_rwx      (perm_rwx),
  .chk_ok        (chk_ok),
  .trap_req      (trap_req),
  .trap_is_fetch (trap_is_fetch),
  .fsr_q         (fsr_q),
  .far_q         (far_q),
  .fault_now     (fault_now)
);

// File: tb/mmu_access_guard_bench.sv
`timescale 1ns/1ps
module mmu_access_guard_bench;
  localparam int VA_W = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            chk_valid = 1'b0;
  logic [2:0]      chk_perm = '0;
  logic            chk_write = 1'b0;
  logic            chk_fetch = 1'b0;
  logic            chk_super = 1'b0;
  logic            chk_modified = 1'b0;
  logic [VA_W-1:0] chk_vaddr = '0;
  logic            nofault_mode = 1'b0;
  logic            traps_enable = 1'b0;
  logic            fsr_rd = 1'b0;
  logic [2:0]      perm_rwx;
  logic            chk_ok;
  logic            trap_req;
  logic            trap_is_fetch;
  logic [7:0]      fsr_q;
  logic [VA_W-1:0] far_q;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mmu_access_guard #(.VA_W(VA_W)) u_mmu_access_guard (
    .clk(clk), .rst(rst), .chk_valid(chk_valid), .chk_perm(chk_perm),
    .chk_write(chk_write), .chk_fetch(chk_fetch), .chk_super(chk_super),
    .chk_modified(chk_modified), .chk_vaddr(chk_vaddr),
    .nofault_mode(nofault_mode), .traps_enable(traps_enable), .fsr_rd(fsr_rd),
    .perm_rwx(perm_rwx), .chk_ok(chk_ok), .trap_req(trap_req),
    .trap_is_fetch(trap_is_fetch), .fsr_q(fsr_q), .far_q(far_q)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R2 rights as {R,W,X}
  function automatic logic [2:0] rights_of(input int p, input bit sup);
    case (p)
      0: return 3'b100;
      1: return 3'b110;
      2: return 3'b101;
      3: return 3'b111;
      4: return 3'b001;
      5: return sup ? 3'b110 : 3'b100;
      6: return sup ? 3'b101 : 3'b000;
      default: return sup ? 3'b111 : 3'b000;
    endcase
  endfunction

  logic [7:0]      m_fsr = 0;
  logic [VA_W-1:0] m_far = 0;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R10 fsr reset", fsr_q, 0);
    check("R10 far reset", far_q, 0);
    check("R10 trap reset", trap_req, 0);

    for (int i = 0; i < 512; i++) begin
      bit wr, fe, sup, md, nf, te, rd;
      int p, err, idx;
      logic [2:0] rt, need, e_perm;
      bit flt, exc, e_ok;
      logic [VA_W-1:0] va;
      idx = i & 7;
      wr = idx[2]; fe = idx[1]; sup = idx[0];
      p  = (i >> 3) & 7;
      md = i[6]; nf = i[7]; te = i[8];
      rd = (i % 3) == 1;
      va = VA_W'(32'h1000_0000 + i * 32'h0001_3571);

      @(negedge clk);
      chk_valid = 1; chk_write = wr; chk_fetch = fe; chk_super = sup;
      chk_perm = p[2:0]; chk_modified = md; nofault_mode = nf;
      traps_enable = te; fsr_rd = rd; chk_vaddr = va;
      #1;
      // R1 required rights
      rt = rights_of(p, sup);
      need = wr ? (fe ? 3'b011 : 3'b010) : (fe ? 3'b001 : 3'b100);
      if (!sup && p >= 6) err = 12;
      else if ((need & ~rt) != 0) err = 8;
      else err = 0;
      flt = (err != 0) && !(nf && !sup);                // R4
      exc = nf || !te;                                  // R7
      e_ok = !flt || exc;
      if (flt) e_perm = exc ? 3'b111 : 3'b000;          // R7, R8
      else e_perm = md ? rt : (rt & 3'b101);            // R3
      check("R1 R2 chk_ok", chk_ok, e_ok);
      check("R3 perm_rwx", perm_rwx, e_perm);
      check("R9 fsr visible", fsr_q, m_fsr);

      @(posedge clk);
      #1;
      if (flt) begin
        logic [7:0] base;
        base = rd ? 8'd0 : m_fsr;                       // R9
        m_fsr = 8'(idx << 5) | 8'(err) | 8'd2 | ((base != 0) ? 8'd1 : 8'd0); // R5 R6
        m_far = va;
      end else if (rd) m_fsr = 0;
      check("R8 trap_req", trap_req, flt && !exc);
      if (flt && !exc) check("R8 trap class", trap_is_fetch, fe);
      check("R5 R6 fsr", fsr_q, m_fsr);
      check("R6 far", far_q, m_far);
    end

    @(negedge clk);
    chk_valid = 0; fsr_rd = 1;
    @(posedge clk); #1;
    check("R9 read clears fsr", fsr_q, 0);
    check("R9 far kept", far_q, m_far);
    check("R8 no trap idle", trap_req, 0);
    @(negedge clk);
    fsr_rd = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL R8 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule